// File: doc/BRIEF.md
# Condition-Flag ALU

This block is a two-operand integer ALU for a simple processor datapath. A 4-bit operation code chooses a bitwise function (AND, XOR, OR, bit-clear), an arithmetic function (add, subtract, reverse subtract, add-with-carry, subtract-with-carry) or a logical shift. The shift amount is taken from operand `b`. Alongside the result, the block produces negative, zero, carry and overflow flags. It also tests a 4-bit condition selector against those flags, which gives one pass/fail bit that branch or predication logic can use.

Subtraction is performed as the first operand plus the inverted second operand plus one. The carry flag therefore reads as "no borrow". With `REG_FLAGS=1`, the flags sit in a register that loads only when `set_flags` is high. The flag outputs and the condition test then use the stored values. A datapath chains multi-word arithmetic by routing `flag_c` back into `carry_in`. With `REG_FLAGS=0`, the block is purely combinational: the flags follow the current operation, and `carry_in` stands in for the previous carry.

Top module: `alu_flags`

## Requirements
- R1: Operation codes 0, 1, 2 and 3 give a&b, a^b, a|b and a&~b. Codes 11 to 15 give a zero result and count as non-arithmetic.
- R2: Code 4 gives a+b, code 5 gives a-b and code 6 gives b-a, all modulo 2^W.
- R3: Code 7 gives a+b+carry_in and code 8 gives a+~b+carry_in. When `flag_c` is fed back to `carry_in`, a two-word add or subtract chains correctly from the low word to the high word.
- R4: Code 9 gives a<<b and code 10 gives a logical a>>b, where b is read as an unsigned amount over its full width. Any amount of W or more gives zero.
- R5: The new N equals the most significant result bit, and the new Z is 1 exactly when the result is all zeros. Both are updated by every operation that sets flags.
- R6: For arithmetic codes, the new C is the carry out of the W-bit sum. After a subtract, C is 1 exactly when a >= b unsigned.
- R7: For arithmetic codes, the new V is the XOR of the carry into the top bit and the carry out of it. For example, 0x7FFFFFFF+1 gives V=1, and 0x80000000-1 gives V=1.
- R8: Bitwise, shift and unused codes leave C and V at their previous values.
- R9: With REG_FLAGS=1, reset clears all four flags. The flags change only on a rising clock edge where `set_flags` is 1, and they hold otherwise.
- R10: Condition codes 0 to 7 pass on Z, !Z, C, !C, N, !N, V and !V, in that order.
- R11: Codes 8 to 13 pass on C&!Z, !C|Z, N==V, N!=V, (N==V)&!Z and (N!=V)|Z, in that order. Codes 14 and 15 always pass.
- R12: With REG_FLAGS=0, the flag outputs and the condition test follow the current operation without delay. The previous C is taken from `carry_in`, and the previous V is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| a | input | W | First operand |
| b | input | W | Second operand and shift amount |
| op | input | 4 | Operation code |
| set_flags | input | 1 | Load the flag register with this operation's flags |
| carry_in | input | 1 | Carry for codes 7 and 8, and previous C in combinational mode |
| cond | input | 4 | Condition selector |
| result | output | W | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_v | output | 1 | Signed overflow flag |
| cond_pass | output | 1 | Selected condition holds on the flags |

## Verification
The bench builds two copies at W=32: one with REG_FLAGS=1, where `flag_c` is looped back to `carry_in`, and one with REG_FLAGS=0 that shares the same operands. The registered copy exposes hold and update timing, two-word carry chaining and the carry and overflow values carried across bitwise operations. The combinational copy exposes same-cycle flags and the carry-in substitution. Both copies sweep all sixteen condition codes after every operation, so each condition is tested against flag combinations reached at the signed and unsigned boundaries.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 32,
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         set_flags,
  input  logic         carry_in,
  input  logic [3:0]   cond,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic         cond_pass
);
  localparam logic [3:0] OP_AND = 4'd0, OP_XOR = 4'd1, OP_OR = 4'd2, OP_BIC = 4'd3;
  localparam logic [3:0] OP_ADD = 4'd4, OP_SUB = 4'd5, OP_RSB = 4'd6, OP_ADC = 4'd7;
  localparam logic [3:0] OP_SBC = 4'd8, OP_SHL = 4'd9, OP_SHR = 4'd10;

  logic [W-1:0] x, y;
  logic         ci, is_arith;
  logic [W:0]   sum;
  logic [W-1:0] low;
  logic         c_old, v_old;
  logic         nf, zf, cf, vf;

  always_comb begin
    x = a;
    y = b;
    ci = 1'b0;
    is_arith = 1'b1;
    case (op)
      OP_ADD: ;
      OP_SUB: begin y = ~b; ci = 1'b1; end
      OP_RSB: begin x = b; y = ~a; ci = 1'b1; end
      OP_ADC: ci = carry_in;
      OP_SBC: begin y = ~b; ci = carry_in; end
      default: is_arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign low = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, ci};

  always_comb begin
    case (op)
      OP_AND: result = a & b;
      OP_XOR: result = a ^ b;
      OP_OR:  result = a | b;
      OP_BIC: result = a & ~b;
      OP_SHL: result = a << b;
      OP_SHR: result = a >> b;
      OP_ADD, OP_SUB, OP_RSB, OP_ADC, OP_SBC: result = sum[W-1:0];
      default: result = '0;
    endcase
  end

  assign nf = result[W-1];
  assign zf = ~|result;
  assign cf = is_arith ? sum[W] : c_old;
  assign vf = is_arith ? (sum[W] ^ low[W-1]) : v_old;

  generate
    if (REG_FLAGS) begin : g_reg
      logic [3:0] nzcv_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nzcv_q <= '0;
        else if (set_flags) nzcv_q <= {nf, zf, cf, vf};
      end
      assign c_old = nzcv_q[1];
      assign v_old = nzcv_q[0];
      assign {flag_n, flag_z, flag_c, flag_v} = nzcv_q;
    end else begin : g_comb
      assign c_old = carry_in;
      assign v_old = 1'b0;
      assign {flag_n, flag_z, flag_c, flag_v} = {nf, zf, cf, vf};
    end
  endgenerate

  always_comb begin
    case (cond)
      4'd0:  cond_pass = flag_z;
      4'd1:  cond_pass = ~flag_z;
      4'd2:  cond_pass = flag_c;
      4'd3:  cond_pass = ~flag_c;
      4'd4:  cond_pass = flag_n;
      4'd5:  cond_pass = ~flag_n;
      4'd6:  cond_pass = flag_v;
      4'd7:  cond_pass = ~flag_v;
      4'd8:  cond_pass = flag_c & ~flag_z;
      4'd9:  cond_pass = ~flag_c | flag_z;
      4'd10: cond_pass = flag_n == flag_v;
      4'd11: cond_pass = flag_n != flag_v;
      4'd12: cond_pass = (flag_n == flag_v) & ~flag_z;
      4'd13: cond_pass = (flag_n != flag_v) | flag_z;
      default: cond_pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int W = 32,
  parameter bit REG_FLAGS = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   op,
  input logic         set_flags,
  input logic [3:0]   cond,
  input logic [W-1:0] result,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v,
  input logic         cond_pass
);
  p_always_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cond >= 4'd14) |-> cond_pass);

  p_ge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'd10) |-> (cond_pass == (flag_n == flag_v)));

  p_eq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'd0) |-> (cond_pass == flag_z));

  generate
    if (REG_FLAGS) begin : g_reg
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v}));

      p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> (flag_z == ($past(result) == '0)));

      p_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> (flag_n == $past(result[W-1])));

      p_keep_cv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && (op < 4'd4 || op > 4'd8)) |=> ($stable(flag_c) && $stable(flag_v)));

      p_noborrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op == 4'd5) |=> (flag_c == ($past(a) >= $past(b))));
    end else begin : g_comb
      p_noborrow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd5) |-> (flag_c == (a >= b)));

      p_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (result == '0) |-> flag_z);
    end
  endgenerate
endmodule

bind alu_flags alu_flags_chk #(.W(W), .REG_FLAGS(REG_FLAGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .set_flags(set_flags),
  .cond(cond), .result(result), .flag_n(flag_n), .flag_z(flag_z),
  .flag_c(flag_c), .flag_v(flag_v), .cond_pass(cond_pass)
);

// File: tb/alu_flags_bench.sv
`timescale 1ns/1ps
module alu_flags_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  op = '0, cond = '0;
  logic        sf = 1'b0, cin = 1'b0;

  logic [31:0] r1, r0;
  logic n1, z1, c1, v1, p1, n0, z0, c0, v0, p0;

  alu_flags #(.W(32), .REG_FLAGS(1'b1)) u_alu_flags (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .set_flags(sf),
    .carry_in(c1), .cond(cond), .result(r1), .flag_n(n1), .flag_z(z1),
    .flag_c(c1), .flag_v(v1), .cond_pass(p1));

  alu_flags #(.W(32), .REG_FLAGS(1'b0)) u_alu_flags_comb (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .set_flags(sf),
    .carry_in(cin), .cond(cond), .result(r0), .flag_n(n0), .flag_z(z0),
    .flag_c(c0), .flag_v(v0), .cond_pass(p0));

  logic mn = 0, mz = 0, mc = 0, mv = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [35:0] model(input logic [31:0] ia, input logic [31:0] ib,
                                        input logic [3:0] iop, input logic cs,
                                        input logic oc, input logic ov);
    logic [32:0] s;
    logic [31:0] x, y, r;
    logic ar, ci, c, v;
    ar = 1; x = ia; y = ib; ci = 0;
    case (iop)
      4: ;
      5: begin y = ~ib; ci = 1; end
      6: begin x = ib; y = ~ia; ci = 1; end
      7: ci = cs;
      8: begin y = ~ib; ci = cs; end
      default: ar = 0;
    endcase
    s = {1'b0, x} + {1'b0, y} + 33'(ci);
    case (iop)
      0: r = ia & ib;
      1: r = ia ^ ib;
      2: r = ia | ib;
      3: r = ia & ~ib;
      9: r = (ib > 31) ? 32'd0 : ia << ib[4:0];
      10: r = (ib > 31) ? 32'd0 : ia >> ib[4:0];
      4, 5, 6, 7, 8: r = s[31:0];
      default: r = 32'd0;
    endcase
    c = ar ? s[32] : oc;
    v = ar ? ((x[31] == y[31]) && (r[31] != x[31])) : ov;
    return {r, r[31], (r == 32'd0), c, v};
  endfunction

  function automatic logic cexp(input logic [3:0] k, input logic n, input logic z,
                                input logic c, input logic v);
    case (k)
      0: return z;
      1: return !z;
      2: return c;
      3: return !c;
      4: return n;
      5: return !n;
      6: return v;
      7: return !v;
      8: return c && !z;
      9: return !c || z;
      10: return n == v;
      11: return n != v;
      12: return (n == v) && !z;
      13: return (n != v) || z;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sweep(input bit reg_copy);
    for (int k = 0; k < 16; k++) begin
      cond = 4'(k);
      #0.05;
      if (reg_copy) chk(k < 8 ? "R10" : "R11", 32'(p1), 32'(cexp(4'(k), mn, mz, mc, mv)));
      else chk(k < 8 ? "R10 R12" : "R11 R12", 32'(p0), 32'(cexp(4'(k), n0e, z0e, c0e, v0e)));
    end
  endtask

  logic n0e, z0e, c0e, v0e;

  task automatic run(input logic [31:0] ia, input logic [31:0] ib, input logic [3:0] iop,
                     input bit isf, input bit icin, input string req);
    logic [35:0] e1, e0;
    @(negedge clk);
    a = ia; b = ib; op = iop; sf = isf; cin = icin; cond = 4'd14;
    e1 = model(ia, ib, iop, mc, mc, mv);
    e0 = model(ia, ib, iop, icin, icin, 1'b0);
    {n0e, z0e, c0e, v0e} = e0[3:0];
    #1;
    chk(req, r1, e1[35:4]);
    chk(req, r0, e0[35:4]);
    chk({req, " R12"}, {28'd0, n0, z0, c0, v0}, {28'd0, e0[3:0]});
    sweep(1'b0);
    @(posedge clk);
    if (isf) {mn, mz, mc, mv} = e1[3:0];
    #1;
    sf = 1'b0;
    chk(isf ? req : "R9", {28'd0, n1, z1, c1, v1}, {28'd0, mn, mz, mc, mv});
    sweep(1'b1);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #7;
    cond = 4'd1;
    #0.5;
    chk("R9", {28'd0, n1, z1, c1, v1}, 32'd0);
    chk("R10", 32'(p1), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9", {28'd0, n1, z1, c1, v1}, 32'd0);

    run(32'hF0F0_1234, 32'h0FF0_FF00, 4'd0, 1, 0, "R1");
    run(32'hF0F0_1234, 32'h0FF0_FF00, 4'd1, 1, 0, "R1");
    run(32'hF0F0_1234, 32'h0FF0_FF00, 4'd2, 1, 0, "R1");
    run(32'hF0F0_1234, 32'h0FF0_FF00, 4'd3, 1, 0, "R1");
    run(32'h1234_5678, 32'h1, 4'd13, 1, 1, "R1");
    run(32'h7FFF_FFFF, 32'h1, 4'd4, 1, 0, "R7");
    run(32'h8000_0000, 32'h1, 4'd5, 1, 1, "R7");
    run(32'h5, 32'h5, 4'd5, 1, 0, "R6");
    run(32'h0, 32'h1, 4'd5, 1, 0, "R6");
    run(32'h3, 32'h10, 4'd6, 1, 0, "R2");
    run(32'hFFFF_FFFF, 32'h1, 4'd4, 1, 0, "R3");
    run(32'h0, 32'h0, 4'd7, 1, 1, "R3");
    run(32'h0, 32'h1, 4'd5, 1, 0, "R3");
    run(32'h5, 32'h0, 4'd8, 1, 1, "R3");
    run(32'hFFFF_FFFF, 32'h1, 4'd4, 1, 0, "R6");
    run(32'h8000_0001, 32'h1, 4'd0, 1, 1, "R8");
    run(32'h8000_0001, 32'd31, 4'd9, 1, 0, "R4");
    run(32'h8000_0001, 32'd32, 4'd9, 1, 0, "R4");
    run(32'h8000_0001, 32'd31, 4'd10, 1, 1, "R4");
    run(32'hFFFF_FFFF, 32'h1_0000, 4'd10, 1, 0, "R4");
    run(32'h0, 32'h0, 4'd2, 0, 0, "R9");
    run(32'h8000_0000, 32'h0, 4'd2, 1, 0, "R5");

    for (int i = 0; i < 300; i++) begin
      logic [3:0] rop;
      logic [31:0] ra, rb;
      rop = 4'($urandom % 16);
      ra = $urandom;
      rb = (rop == 4'd9 || rop == 4'd10) ? ($urandom % 40) : $urandom;
      if (i % 7 == 0) rb = ra;
      run(ra, rb, rop, 1'($urandom % 2), 1'($urandom % 2), "R2 R5");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule